// File: doc/BRIEF.md
# Cache Block Refill Sequencer with Selectable Memory Organization

After a cache miss, this block fetches one 16-word cache block from a modelled main memory. The memory is a small array held in four banks. The sequencer takes a block number. It then steps through a fixed schedule: one cycle to present the address, then access latency rounds counted out by a counter, then transfer beats. The schedule depends on how the memory is organized, and a mode input picks the organization: a one-word-wide memory, a four-word-wide memory, or four word-interleaved banks.

Each transfer beat carries a four-lane data bus, a lane mask and the word offset of lane 0. The cache side writes the masked lanes. A one-cycle completion pulse follows the final beat. The block also reports how many cycles the refill occupied, so the miss penalty of each organization can be observed directly.

Top module: `refill_ctrl`

## Requirements
- R1: After reset, and in the cycle after any reset, busy, beat_valid and done are all low.
- R2: A request is taken only while busy is low. A req_valid raised during a refill changes nothing in that refill's beats, and it does not start a second refill once the first one ends, provided it is lowered before the done cycle.
- R3: busy is high from the cycle after acceptance through the done cycle, and it is low in the next cycle.
- R4: Mode 0 (one-word memory): cycle 1 after acceptance presents the address. Each of the 16 words then takes 10 access cycles and 1 beat cycle, so beats fall in cycles 12, 23, …, 177, and the penalty is 177.
- R5: Mode 1 (four-word memory): 4 rounds of 10 access cycles plus one beat with mask 4'b1111. Beats fall in cycles 12, 23, 34 and 45, and the penalty is 45.
- R6: Mode 2 (interleaved banks): 4 rounds, each with 10 access cycles shared by all banks followed by 4 consecutive beats. Beats fall in cycles 12–15, 26–29, 40–43 and 54–57, and the penalty is 57.
- R7: Word offset w travels on lane (w mod 4) with beat_base = w rounded down to a multiple of 4, and words arrive in ascending offset order. In modes 0, 2 and 3 each beat carries exactly one mask bit.
- R8: Memory word address a = blk*16 + w holds {16'hC0DE ^ a[15:0], a[15:0]}, and that value appears on its lane.
- R9: done is a one-cycle pulse in the cycle after the last beat. From the done cycle until the next done, penalty holds the number of cycles from cycle 1 through the last beat.
- R10: mode is sampled at acceptance, and later changes to it have no effect on the refill in progress.
- R11: Mode 3 follows the mode 0 schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request |
| req_blk | input | BLK_W | Block number to fetch |
| mode | input | 2 | Memory organization: 0 narrow, 1 wide, 2 interleaved, 3 narrow |
| busy | output | 1 | Refill in progress |
| beat_valid | output | 1 | Transfer beat this cycle |
| beat_mask | output | 4 | Lanes carrying valid words |
| beat_base | output | 4 | Word offset of lane 0 |
| beat_data | output | 4*DATA_W | Four lanes of word data |
| done | output | 1 | Refill-complete pulse |
| penalty | output | CNT_W | Cycles used by the last refill |

## Verification
The bench goes after four corner cases. The first is the one-cycle offset between the address cycle and the first access: a counter off by one would move every beat and give penalties of 176 or 178. The second is the round boundary in interleaved mode: a sequencer that went back to access after every word would produce the narrow schedule, and one that never went back would put words 4–15 right after the first access. The third is a request arriving in mid-refill, which a design with a loose idle check would take, corrupting the block number or starting an extra refill. The last is a mode toggle after acceptance and the reserved mode value, which show whether the organization is actually latched and decoded.

// File: rtl/refill_ctrl.sv
module refill_ctrl #(
  parameter int DATA_W  = 32,
  parameter int BLK_W   = 4,
  parameter int ACC_LAT = 10,
  parameter int CNT_W   = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic [1:0]            mode,
  output logic                  busy,
  output logic                  beat_valid,
  output logic [3:0]            beat_mask,
  output logic [3:0]            beat_base,
  output logic [4*DATA_W-1:0]   beat_data,
  output logic                  done,
  output logic [CNT_W-1:0]      penalty
);
  localparam int ROWS  = (1 << BLK_W) * 4;
  localparam int ROW_W = BLK_W + 2;
  localparam int LAT_W = $clog2(ACC_LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_ACC, S_XFER, S_DONE} st_t;

  st_t               st;
  logic [1:0]        mode_q;
  logic [BLK_W-1:0]  blk_q;
  logic [3:0]        idx;
  logic [LAT_W-1:0]  lat;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] bank [4][ROWS];

  wire is_wide = (mode_q == 2'd1);
  wire is_il   = (mode_q == 2'd2);
  wire last    = is_wide ? (idx[3:2] == 2'd3) : (idx == 4'd15);
  wire [ROW_W-1:0] row = {blk_q, idx[3:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++)
        for (int b = 0; b < 4; b++) begin
          logic [15:0] a;
          a = 16'(r * 4 + b);
          bank[b][r] <= DATA_W'({16'hC0DE ^ a, a});
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      mode_q  <= 2'd0;
      blk_q   <= '0;
      idx     <= '0;
      lat     <= '0;
      cnt     <= '0;
      penalty <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_SEND;
          mode_q <= mode;
          blk_q  <= req_blk;
          idx    <= '0;
          cnt    <= '0;
        end
        S_SEND: begin
          cnt <= cnt + 1'b1;
          lat <= '0;
          st  <= S_ACC;
        end
        S_ACC: begin
          cnt <= cnt + 1'b1;
          if (lat == LAT_W'(ACC_LAT - 1)) begin
            lat <= '0;
            st  <= S_XFER;
          end else begin
            lat <= lat + 1'b1;
          end
        end
        S_XFER: begin
          cnt <= cnt + 1'b1;
          if (last) begin
            penalty <= cnt + 1'b1;
            st      <= S_DONE;
          end else if (is_wide) begin
            idx <= idx + 4'd4;
            st  <= S_ACC;
          end else begin
            idx <= idx + 4'd1;
            st  <= (is_il && idx[1:0] != 2'd3) ? S_XFER : S_ACC;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign beat_valid = (st == S_XFER);
  assign done       = (st == S_DONE);
  assign beat_base  = {idx[3:2], 2'b00};
  assign beat_mask  = !beat_valid ? 4'b0000 :
                      is_wide     ? 4'b1111 : (4'b0001 << idx[1:0]);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign beat_data[l*DATA_W +: DATA_W] = bank[l][row];
  end
endmodule

// File: rtl/refill_ctrl_chk.sv
module refill_ctrl_chk #(
  parameter int ACC_LAT = 10,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             beat_valid,
  input logic [3:0]       beat_mask,
  input logic             done,
  input logic [CNT_W-1:0] penalty,
  input logic [1:0]       mode_q
);
  localparam int P_NAR  = 1 + 16 * (ACC_LAT + 1);
  localparam int P_WIDE = 1 + 4 * (ACC_LAT + 1);
  localparam int P_IL   = 1 + 4 * (ACC_LAT + 4);

  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!busy && !beat_valid && !done)); // R1
  AST_BEAT_IN_BUSY: assert property (@(posedge clk) disable iff (rst) beat_valid |-> busy); // R3
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst) done |=> (!busy && !done)); // R9
  AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && mode_q != 2'd1) |-> ($countones(beat_mask) == 1)); // R7
  AST_WIDE_FULL: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && mode_q == 2'd1) |-> (beat_mask == 4'hF)); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(busy)) |-> $stable(mode_q)); // R10
  AST_PENALTY_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(penalty) == (mode_q == 2'd1 ? P_WIDE : mode_q == 2'd2 ? P_IL : P_NAR))); // R4
endmodule

bind refill_ctrl refill_ctrl_chk #(.ACC_LAT(ACC_LAT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .beat_valid(beat_valid), .beat_mask(beat_mask),
  .done(done), .penalty(penalty), .mode_q(mode_q)
);

// File: tb/refill_ctrl_tb.sv
module refill_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1, req_valid = 1'b0;
  logic [3:0]  req_blk = '0;
  logic [1:0]  mode = '0;
  logic        busy, beat_valid, done;
  logic [3:0]  beat_mask, beat_base;
  logic [127:0] beat_data;
  logic [7:0]  penalty;

  refill_ctrl u_dut (.clk(clk), .rst(rst), .req_valid(req_valid), .req_blk(req_blk), .mode(mode),
    .busy(busy), .beat_valid(beat_valid), .beat_mask(beat_mask), .beat_base(beat_base),
    .beat_data(beat_data), .done(done), .penalty(penalty));

  int checks = 0, fails = 0, cyc = 0;
  int e_mask [0:255];
  int e_base [0:255];
  int e_pen;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int a);
    logic [15:0] s = 16'(a);
    return {16'hC0DE ^ s, s};
  endfunction

  task automatic build(int m);
    int t = 1;
    for (int i = 0; i < 256; i++) begin e_mask[i] = 0; e_base[i] = 0; end
    if (m == 1) begin
      for (int g = 0; g < 4; g++) begin t += 11; e_mask[t] = 15; e_base[t] = 4*g; end
    end else if (m == 2) begin
      for (int g = 0; g < 4; g++) begin
        t += 10;
        for (int j = 0; j < 4; j++) begin t += 1; e_mask[t] = 1 << j; e_base[t] = 4*g; end
      end
    end else begin
      for (int w = 0; w < 16; w++) begin t += 11; e_mask[t] = 1 << (w % 4); e_base[t] = w & 12; end
    end
    e_pen = t;
  endtask

  task automatic refill(int m, int blk, int m_later, bit poke);
    string rq;
    rq = (m == 1) ? "R5" : (m == 2) ? "R6" : (m == 3) ? "R11" : "R4";
    @(negedge clk);
    req_valid = 1'b1; mode = 2'(m); req_blk = 4'(blk);
    build(m);
    for (int k = 1; k <= e_pen + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin req_valid = 1'b0; mode = 2'(m_later); end
      if (poke && k == 20) begin req_valid = 1'b1; req_blk = 4'(blk ^ 1); end
      if (poke && k == 40) req_valid = 1'b0;
      chk(busy == 1'b1, "R3", $sformatf("busy cycle %0d", k), busy, 1);
      chk(beat_valid == (e_mask[k] != 0), rq, $sformatf("beat_valid cycle %0d", k), beat_valid, e_mask[k] != 0);
      if (e_mask[k] != 0) begin
        chk(beat_mask == 4'(e_mask[k]), "R7", $sformatf("mask cycle %0d", k), beat_mask, e_mask[k]);
        chk(beat_base == 4'(e_base[k]), "R7", $sformatf("base cycle %0d", k), beat_base, e_base[k]);
        for (int l = 0; l < 4; l++)
          if (e_mask[k][l])
            chk(beat_data[l*32 +: 32] == pat(blk*16 + e_base[k] + l), "R8",
                $sformatf("lane %0d cycle %0d", l, k), beat_data[l*32 +: 32], pat(blk*16 + e_base[k] + l));
      end
      chk(done == (k == e_pen + 1), "R9", $sformatf("done cycle %0d", k), done, k == e_pen + 1);
      if (k == e_pen + 1) chk(penalty == 8'(e_pen), rq, "penalty at done", penalty, e_pen);
    end
    @(negedge clk);
    chk(busy == 1'b0, poke ? "R2" : "R3", "busy after done", busy, 0);
    chk(done == 1'b0, "R9", "done pulse width", done, 0);
    chk(penalty == 8'(e_pen), "R9", "penalty held", penalty, e_pen);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !beat_valid && !done, "R1", "idle after reset", {busy, beat_valid, done}, 0);
    refill(0, 3, 1, 1'b0);   // R4, R10: mode moved to wide mid-refill
    refill(1, 5, 2, 1'b1);   // R5, R2: request poked while busy
    refill(2, 9, 0, 1'b0);   // R6
    refill(3, 15, 1, 1'b0);  // R11
    refill(2, 0, 1, 1'b1);   // R6, R2, R10
    @(negedge clk);
    req_valid = 1'b1; mode = 2'd1; req_blk = 4'd7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !beat_valid && !done, "R1", "quiet after mid-refill reset", {busy, beat_valid, done}, 0);
    @(negedge clk);
    chk(!busy, "R1", "stays idle after reset", busy, 0);
    refill(1, 12, 0, 1'b0);  // R5 after recovery
    finish_run();
  end
endmodule